// File: doc/BRIEF.md
# Segmented Waveform Sequence Player

This block produces the read-address stream for a sample memory that feeds a waveform generator. Waveforms are stored as words of four samples. A small segment table, read by the player through a combinational lookup port, describes each segment in five fields:

- where the waveform starts (a word address);
- how long it is (in samples);
- how many times it is repeated;
- whether it carries a marker;
- at which sample the marker sits.

While a segment plays, the block issues one word address per clock. It raises a stretched marker pulse when the marked word comes back from the synchronous memory.

In sequence mode the player walks table entries from index 0 up to a programmable last index. In waveform mode it uses only the one entry picked by a select input. Start pulses from a trigger controller begin playback. Four trigger behaviours decide what happens after each segment:

- **single**: play the list once, then idle;
- **continuous**: wrap around without stopping;
- **stepped**: wait for a start before each further segment;
- **burst**: repeat each segment until the next start arrives.

Every entry is checked for legality as it is loaded. An illegal entry stops playback with an error flag.

Top module: `wave_seq_player`

## Requirements
- R1: After reset, `busy`, `error`, `rd_en` and `marker` are all 0.
- R2: In sequence mode (`seq_mode`=1), entries 0 through `last_idx` play in index order. Each pass of an entry reads word addresses `start` to `start + len/4 - 1`, one per clock. An entry plays `loops` passes back to back. There is exactly one cycle with `rd_en` low before the first read of each segment.
- R3: In waveform mode (`seq_mode`=0), only entry `wave_sel` is played, with the same per-entry rules as R2.
- R4: With `trig_mode`=0 (single), the block returns to idle (`busy`=0) after the last segment finishes. Start pulses seen while busy have no effect on the address stream.
- R5: With `trig_mode`=1 (continuous), the first entry follows the last one again without any start pulse.
- R6: With `trig_mode`=2 (stepped), the first segment starts on a start pulse. Each later segment waits with `busy`=1 and `rd_en`=0 until another start pulse. After the last segment the block goes idle.
- R7: With `trig_mode`=3 (burst), the loop count is ignored, and 0 is accepted. The current pass repeats until a start pulse is seen. The pass in progress then completes, and play moves to the next entry, wrapping from the last entry to the first.
- R8: When an entry's marker is enabled, `marker` rises in the cycle after word `mark/4` of a pass is read. It stays high for exactly `MARK_HOLD` (16) cycles, and a new marked read restarts that count.
- R9: An entry is illegal if any of the following holds: its length is not a multiple of 4; its length is below 16; its loop count is 0 outside burst mode; or its marker is enabled at a position that is not a multiple of 4 or is not below the length. Loading an illegal entry sets `error`=1 and `busy`=0 with no reads, and this holds until reset.
- R10: While `error` is 1, start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse from trigger controller |
| seq_mode | input | 1 | 1 = sequence mode, 0 = waveform mode |
| trig_mode | input | 2 | 0 single, 1 continuous, 2 stepped, 3 burst |
| wave_sel | input | IDX_W | Entry played in waveform mode |
| last_idx | input | IDX_W | Last entry of the sequence |
| tbl_idx | output | IDX_W | Segment table lookup index |
| tbl_start | input | ADDR_W | Entry start word address |
| tbl_len | input | LEN_W | Entry length in samples |
| tbl_loops | input | LOOP_W | Entry loop count |
| tbl_mark | input | LEN_W | Entry marker sample position |
| tbl_mark_en | input | 1 | Entry marker enable |
| rd_en | output | 1 | Sample memory read strobe |
| rd_addr | output | ADDR_W | Sample memory word address |
| marker | output | 1 | Stretched marker pulse |
| busy | output | 1 | Playback active (including waits) |
| error | output | 1 | Illegal entry encountered |

## Verification
A wrong loop counter or end-of-pass comparison shows up at the address port within one pass: a read arrives that the scoreboard did not expect, or an expected read never comes. A wrong marker word or a wrong stretch length moves the edge of `marker` by whole cycles, and the bench catches this in the first cycle where the level differs from its model. A sequencing state that stays stuck or jumps wrongly appears as `busy`/`rd_en` disagreeing with the expected idle, wait or wrap behaviour a few cycles after the segment boundary.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PLAY,
        ST_WAIT,
        ST_ERR
    } wsp_state_e;

    typedef enum logic [1:0] {
        TM_SINGLE = 2'd0,
        TM_CONT   = 2'd1,
        TM_STEP   = 2'd2,
        TM_BURST  = 2'd3
    } wsp_trig_e;

endpackage

// File: rtl/wsp_entry_check.sv
module wsp_entry_check #(
    parameter int LEN_W   = 16,
    parameter int LOOP_W  = 24,
    parameter int MIN_LEN = 16
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [LOOP_W-1:0] loops,
    input  logic [LEN_W-1:0]  mark,
    input  logic              mark_en,
    input  logic              burst,
    output logic              legal
);
    logic bad_quantum;
    logic bad_short;
    logic bad_loops;
    logic bad_mark;

    always_comb begin
        bad_quantum = (len[1:0] != 2'b00);
        bad_short   = (len < LEN_W'(MIN_LEN));
        bad_loops   = !burst && (loops == '0);
        bad_mark    = mark_en && ((mark[1:0] != 2'b00) || (mark >= len));
        legal       = !(bad_quantum || bad_short || bad_loops || bad_mark);
    end

endmodule

// File: rtl/wsp_marker_pulse.sv
module wsp_marker_pulse #(
    parameter int MARK_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic marker
);
    localparam int CW = $clog2(MARK_HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (fire) begin
            cnt_d = CW'(MARK_HOLD);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign marker = (cnt_q != '0);

endmodule

// File: rtl/wave_seq_player.sv
module wave_seq_player
    import wsp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 16,
    parameter int LOOP_W    = 24,
    parameter int IDX_W     = 3,
    parameter int MIN_LEN   = 16,
    parameter int MARK_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              seq_mode,
    input  logic [1:0]        trig_mode,
    input  logic [IDX_W-1:0]  wave_sel,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_start,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic [LOOP_W-1:0] tbl_loops,
    input  logic [LEN_W-1:0]  tbl_mark,
    input  logic              tbl_mark_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              marker,
    output logic              busy,
    output logic              error
);
    localparam int WRD_W = LEN_W - 2;

    typedef struct packed {
        wsp_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [WRD_W-1:0]  wlast;
        logic [WRD_W-1:0]  word;
        logic [WRD_W-1:0]  mword;
        logic              mken;
        logic [LOOP_W-1:0] left;
        logic              pend;
    } regs_t;

    regs_t r_d, r_q;

    wsp_trig_e        tmode;
    logic             burst;
    logic             legal;
    logic             fire;
    logic             pass_end;
    logic             advance;
    logic [IDX_W-1:0] first_idx;
    logic [IDX_W-1:0] end_idx;

    assign tmode     = wsp_trig_e'(trig_mode);
    assign burst     = (tmode == TM_BURST);
    assign first_idx = seq_mode ? '0 : wave_sel;
    assign end_idx   = seq_mode ? last_idx : wave_sel;
    assign tbl_idx   = r_q.idx;

    wsp_entry_check #(
        .LEN_W  (LEN_W),
        .LOOP_W (LOOP_W),
        .MIN_LEN(MIN_LEN)
    ) u_check (
        .len    (tbl_len),
        .loops  (tbl_loops),
        .mark   (tbl_mark),
        .mark_en(tbl_mark_en),
        .burst  (burst),
        .legal  (legal)
    );

    always_comb begin
        r_d      = r_q;
        fire     = 1'b0;
        pass_end = 1'b0;
        advance  = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.idx = first_idx;
                    r_d.st  = ST_LOAD;
                end
            end

            ST_LOAD: begin
                if (!legal) begin
                    r_d.st = ST_ERR;
                end else begin
                    r_d.base  = tbl_start;
                    r_d.wlast = tbl_len[LEN_W-1:2] - WRD_W'(1);
                    r_d.word  = '0;
                    r_d.mword = tbl_mark[LEN_W-1:2];
                    r_d.mken  = tbl_mark_en;
                    r_d.left  = tbl_loops;
                    r_d.pend  = 1'b0;
                    r_d.st    = ST_PLAY;
                end
            end

            ST_PLAY: begin
                fire     = r_q.mken && (r_q.word == r_q.mword);
                pass_end = (r_q.word == r_q.wlast);
                if (burst && start) begin
                    r_d.pend = 1'b1;
                end
                if (burst) begin
                    advance = pass_end && (r_q.pend || start);
                end else begin
                    advance = pass_end && (r_q.left == LOOP_W'(1));
                end

                if (advance) begin
                    r_d.pend = 1'b0;
                    if (r_q.idx == end_idx) begin
                        if (tmode == TM_SINGLE || tmode == TM_STEP) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.idx = first_idx;
                            r_d.st  = ST_LOAD;
                        end
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                        r_d.st  = (tmode == TM_STEP) ? ST_WAIT : ST_LOAD;
                    end
                end else if (pass_end) begin
                    r_d.word = '0;
                    if (!burst) begin
                        r_d.left = r_q.left - LOOP_W'(1);
                    end
                end else begin
                    r_d.word = r_q.word + WRD_W'(1);
                end
            end

            ST_WAIT: begin
                if (start) begin
                    r_d.st = ST_LOAD;
                end
            end

            ST_ERR: begin
                r_d.st = ST_ERR;
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    wsp_marker_pulse #(
        .MARK_HOLD(MARK_HOLD)
    ) u_mark (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .marker(marker)
    );

    assign rd_en   = (r_q.st == ST_PLAY);
    assign rd_addr = r_q.base + ADDR_W'(r_q.word);
    assign busy    = (r_q.st != ST_IDLE) && (r_q.st != ST_ERR);
    assign error   = (r_q.st == ST_ERR);

endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
    parameter int MARK_HOLD = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic rd_en,
    input logic marker,
    input logic busy,
    input logic error
);
    localparam int RW = $clog2(MARK_HOLD + 2) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (marker) begin
            if (run_q != {RW{1'b1}}) begin
                run_q <= run_q + RW'(1);
            end
        end else begin
            run_q <= '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!busy && !error && !rd_en)); // R1
    AST_READ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy); // R2
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R10
    AST_MARK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(marker) |-> (run_q >= RW'(MARK_HOLD))); // R8
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n) error |-> (!rd_en && !busy)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) error |=> error); // R9

endmodule

bind wave_seq_player wsp_checker #(
    .MARK_HOLD(MARK_HOLD)
) u_wsp_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .rd_en (rd_en),
    .marker(marker),
    .busy  (busy),
    .error (error)
);

// File: tb/sim_wave_seq_player.sv
module sim_wave_seq_player;

    localparam int ADDR_W = 16;
    localparam int LEN_W  = 16;
    localparam int LOOP_W = 24;
    localparam int IDX_W  = 3;
    localparam int HOLD   = 16;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        bit                mark;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_drv = 1'b0;
    logic              rst_n;
    logic              start = 1'b0;
    logic              seq_mode = 1'b1;
    logic [1:0]        trig_mode = 2'd0;
    logic [IDX_W-1:0]  wave_sel = '0;
    logic [IDX_W-1:0]  last_idx = '0;
    logic [IDX_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] tbl_start;
    logic [LEN_W-1:0]  tbl_len;
    logic [LOOP_W-1:0] tbl_loops;
    logic [LEN_W-1:0]  tbl_mark;
    logic              tbl_mark_en;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              marker;
    logic              busy;
    logic              error;

    logic [ADDR_W-1:0] t_start [8];
    logic [LEN_W-1:0]  t_len   [8];
    logic [LOOP_W-1:0] t_loops [8];
    logic [LEN_W-1:0]  t_mark  [8];
    logic              t_mken  [8];

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    int    nreads   = 0;
    int    mcnt     = 0;
    int    kill_cnt = 0;
    int    kill_ack = 0;
    bit    stop_on_drain = 1'b0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    assign rst_n       = rst_drv && (kill_cnt == kill_ack);
    assign tbl_start   = t_start[tbl_idx];
    assign tbl_len     = t_len[tbl_idx];
    assign tbl_loops   = t_loops[tbl_idx];
    assign tbl_mark    = t_mark[tbl_idx];
    assign tbl_mark_en = t_mken[tbl_idx];

    wave_seq_player #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W), .IDX_W(IDX_W),
        .MIN_LEN(16), .MARK_HOLD(HOLD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .seq_mode(seq_mode),
        .trig_mode(trig_mode), .wave_sel(wave_sel), .last_idx(last_idx),
        .tbl_idx(tbl_idx), .tbl_start(tbl_start), .tbl_len(tbl_len),
        .tbl_loops(tbl_loops), .tbl_mark(tbl_mark), .tbl_mark_en(tbl_mark_en),
        .rd_en(rd_en), .rd_addr(rd_addr), .marker(marker), .busy(busy),
        .error(error)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every read and tracks the marker level (R2, R8)
    always @(negedge clk) begin
        if (!rst_n) begin
            mcnt = 0;
        end else begin
            bit fire_now;
            item_t it;
            fire_now = 1'b0;
            chk(marker == (mcnt != 0), "R8", "marker level", int'(marker), int'(mcnt != 0));
            if (rd_en) begin
                nreads++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected read addr", int'(rd_addr), -1);
                end else begin
                    it = exp_q.pop_front();
                    chk(rd_addr == it.addr, "R2", "read address", int'(rd_addr), int'(it.addr));
                    fire_now = it.mark;
                    if (stop_on_drain && exp_q.size() == 0) kill_cnt++;
                end
            end
            if (fire_now) mcnt = HOLD;
            else if (mcnt > 0) mcnt--;
        end
    end

    task automatic push_seg(input int i, input int passes);
        for (int p = 0; p < passes; p++) begin
            for (int w = 0; w < int'(t_len[i]) / 4; w++) begin
                item_t it;
                it.addr = t_start[i] + ADDR_W'(w);
                it.mark = t_mken[i] && (w == int'(t_mark[i]) / 4);
                exp_q.push_back(it);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_drv = 1'b0;
        stop_on_drain = 1'b0;
        kill_ack = kill_cnt;
        repeat (3) @(negedge clk);
        rst_drv = 1'b1;
        @(negedge clk);
        nreads = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic wait_drain_kill();
        while (kill_cnt == kill_ack) @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        t_start[0] = 16'h0100; t_len[0] = 16; t_loops[0] = 2; t_mark[0] = 8;  t_mken[0] = 1;
        t_start[1] = 16'h0200; t_len[1] = 32; t_loops[1] = 1; t_mark[1] = 0;  t_mken[1] = 0;
        t_start[2] = 16'h0300; t_len[2] = 20; t_loops[2] = 3; t_mark[2] = 0;  t_mken[2] = 1;
        t_start[3] = 16'h0400; t_len[3] = 16; t_loops[3] = 0; t_mark[3] = 12; t_mken[3] = 1;
        t_start[4] = 16'h0500; t_len[4] = 18; t_loops[4] = 1; t_mark[4] = 0;  t_mken[4] = 0;
        t_start[5] = 16'h0600; t_len[5] = 12; t_loops[5] = 1; t_mark[5] = 0;  t_mken[5] = 0;
        t_start[6] = 16'h0700; t_len[6] = 16; t_loops[6] = 0; t_mark[6] = 0;  t_mken[6] = 0;
        t_start[7] = 16'h0800; t_len[7] = 16; t_loops[7] = 1; t_mark[7] = 6;  t_mken[7] = 1;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !error && !rd_en && !marker, "R1", "outputs in reset", int'({busy, error, rd_en, marker}), 0);
        rst_drv = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !error && !rd_en && !marker, "R1", "outputs after reset", int'({busy, error, rd_en, marker}), 0);

        // R2 / R4: sequence single, extra start mid-play ignored
        seq_mode = 1'b1; trig_mode = 2'd0; last_idx = 3'd2;
        push_seg(0, 2); push_seg(1, 1); push_seg(2, 3);
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_start();
        wait_idle();
        chk(exp_q.size() == 0, "R2", "sequence reads left", exp_q.size(), 0);
        chk(!busy, "R4", "idle after single sequence", int'(busy), 0);
        chk(nreads == 31, "R4", "read count single", nreads, 31);

        // R3: waveform mode plays only the selected entry
        do_reset();
        seq_mode = 1'b0; wave_sel = 3'd1; trig_mode = 2'd0;
        push_seg(1, 1);
        pulse_start();
        wait_idle();
        chk(exp_q.size() == 0 && nreads == 8, "R3", "waveform reads", nreads, 8);

        // R5: continuous wraps without start
        do_reset();
        seq_mode = 1'b1; last_idx = 3'd1; trig_mode = 2'd1;
        for (int k = 0; k < 3; k++) begin push_seg(0, 2); push_seg(1, 1); end
        stop_on_drain = 1'b1;
        pulse_start();
        wait_drain_kill();
        chk(nreads == 48, "R5", "continuous read count", nreads, 48);

        // R6: stepped waits before each further segment
        do_reset();
        seq_mode = 1'b1; last_idx = 3'd1; trig_mode = 2'd2;
        push_seg(0, 2);
        pulse_start();
        for (int k = 0; k < 30 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(busy && !rd_en, "R6", "waiting for step", int'({busy, rd_en}), 2);
        push_seg(1, 1);
        pulse_start();
        wait_idle();
        chk(exp_q.size() == 0 && !busy, "R6", "stepped end", exp_q.size(), 0);

        // R7: burst repeats until start, then advances and wraps
        do_reset();
        seq_mode = 1'b1; last_idx = 3'd1; trig_mode = 2'd3;
        push_seg(0, 3); push_seg(1, 1); push_seg(0, 1);
        stop_on_drain = 1'b1;
        pulse_start();
        while (nreads < 10) @(posedge clk);
        pulse_start();
        while (nreads < 14) @(posedge clk);
        pulse_start();
        wait_drain_kill();
        chk(nreads == 24, "R7", "burst read count", nreads, 24);

        // R7 / R8: zero loop count legal in burst, marker retrigger
        do_reset();
        seq_mode = 1'b0; wave_sel = 3'd3; trig_mode = 2'd3;
        push_seg(3, 3);
        stop_on_drain = 1'b1;
        pulse_start();
        while (nreads < 5) @(posedge clk);
        pulse_start();
        wait_drain_kill();
        chk(nreads == 12, "R7", "burst zero-loop entry", nreads, 12);

        // R9 / R10: illegal entries halt with error; start then ignored
        for (int i = 4; i < 8; i++) begin
            do_reset();
            seq_mode = 1'b0; wave_sel = IDX_W'(i); trig_mode = 2'd0;
            pulse_start();
            repeat (4) @(negedge clk);
            chk(error && !busy && !rd_en, "R9", $sformatf("illegal entry %0d", i), int'({error, busy, rd_en}), 4);
            pulse_start();
            repeat (4) @(negedge clk);
            chk(error && !busy && nreads == 0, "R10", "start ignored in error", nreads, 0);
        end
        do_reset();
        chk(!error, "R9", "error cleared by reset", int'(error), 0);

        repeat (20) @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule